// File: doc/BRIEF.md
# Conflict Flag and Bus-Error Status Unit

This unit collects "no-change conflict" events for a bank of timer outputs, one event line per output. Each event sets a sticky flag bit, and software clears that bit by writing a 1 to it. A companion enable register chooses which flagged outputs may raise the single interrupt line. The interrupt stays high for as long as at least one enabled flag remains set.

The same flag word also carries two sticky bus-error indicators. They record which counter half rejected the most recent illegal register write: the low/unified half, the high half, or both when one word write failed in both halves. Each new error replaces both indicators. Software clears them the same way as the conflict flags, by writing 1s to them.

Software reaches the unit through a small register port with write-only strobes and a read mux that is always valid. Word address 0 is the enable register and word address 1 is the flag register. Addresses 2 and 3 read as zero and ignore writes.

Top module: `conflict_status_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the enable register, every conflict flag and both bus-error bits are 0, and `irq_req` is 0.
- R2: A write to address 0 loads bits [NUM_OUT-1:0] of the enable register from `reg_wdata`. Reading address 0 returns that value in bits [15:0] with bits [31:16] zero.
- R3: A pulse on `conflict_evt[n]` sets flag bit n at the next rising edge. The bit then stays set, visible at bit n of address 1, until software clears it.
- R4: A write to address 1 with bit n of `reg_wdata` at 1 clears flag bit n. A 0 in bit n leaves flag bit n as it was.
- R5: `irq_req` is 1 exactly when some bit position has both its enable bit and its flag bit at 1. It follows register state with no extra delay.
- R6: When a bus-error strobe arrives, bit 30 of address 1 becomes `err_lo_wr` and bit 31 becomes `err_hi_wr`, replacing any earlier error record. A low-only error therefore clears a previously set bit 31, and a high-only error clears bit 30.
- R7: When `err_lo_wr` and `err_hi_wr` arrive in the same cycle, bits 30 and 31 are both set.
- R8: A write to address 1 with 1s in bit 30 and/or bit 31 clears the matching bus-error bit, provided no bus-error strobe arrives in that same cycle. A 0 in those bits leaves them unchanged.
- R9: If a set and a write-1 clear hit the same bit in one cycle, the set wins. For a conflict flag the set is its event; for the bus-error bits the set is a new strobe.
- R10: Bits 29:16 of address 1 always read 0. Addresses 2 and 3 read 0, and writes to them change neither the enable nor the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conflict_evt | input | NUM_OUT | One-cycle conflict event per output |
| err_lo_wr | input | 1 | Illegal write rejected by the low/unified half |
| err_hi_wr | input | 1 | Illegal write rejected by the high half |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 enable, 1 flags |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_req | output | 1 | Interrupt request |

## Verification
There are two cases where a set and a clear can land on the same bit in one cycle. The first is a conflict event arriving together with a software write-1 clear of that flag. The second is a new bus-error strobe arriving together with a write that clears bits 30/31. The bench provokes both cases directly, on their own and alongside unrelated bits. It also drives them through a long random mix of events, strobes and writes, so that collisions happen on many bit positions. Each result is judged against a bench model that applies the clear first and the set last, and the flag word and `irq_req` are compared after every cycle.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 2;
    localparam int BERR_LO_POS = 30;
    localparam int BERR_HI_POS = 31;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 2'd0,
        REG_FLAG   = 2'd1
    } cfs_reg_e;

    typedef struct packed {
        logic en_we;
        logic fl_we;
    } cfs_wsel_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } cfs_berr_t;

    function automatic cfs_wsel_t cfs_decode(input logic wr, input logic [ADDR_W-1:0] addr);
        cfs_wsel_t s;
        s.en_we = wr && (addr == REG_ENABLE);
        s.fl_we = wr && (addr == REG_FLAG);
        return s;
    endfunction

endpackage

// File: rtl/cfs_flag_array.sv
module cfs_flag_array #(
    parameter int NUM_OUT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OUT-1:0] set_vec,
    input  logic [NUM_OUT-1:0] clr_vec,
    output logic [NUM_OUT-1:0] flags
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_vec[i]) flags[i] <= 1'b0;
        end
    end

    assert_set_sticks_R3: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        ((clr_vec & ~set_vec) != '0) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));

    assert_untouched_hold_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((flags ^ $past(flags)) & ~$past(set_vec | clr_vec)) == '0));

endmodule

// File: rtl/cfs_berr_track.sv
module cfs_berr_track
    import cfs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cfs_berr_t err_in,
    input  cfs_berr_t clr_in,
    output cfs_berr_t rec
);

    logic new_err;
    assign new_err = err_in.lo | err_in.hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec <= '0;
        end else if (new_err) begin
            rec <= err_in;
        end else begin
            rec.lo <= rec.lo & ~clr_in.lo;
            rec.hi <= rec.hi & ~clr_in.hi;
        end
    end

    assert_latest_error_R6: assert property (@(posedge clk) disable iff (rst)
        (err_in.lo || err_in.hi) |=> (rec.lo == $past(err_in.lo) && rec.hi == $past(err_in.hi)));

    assert_both_halves_R7: assert property (@(posedge clk) disable iff (rst)
        (err_in.lo && err_in.hi) |=> (rec.lo && rec.hi));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (!err_in.lo && !err_in.hi && clr_in.lo) |=> !rec.lo);

endmodule

// File: rtl/cfs_read_mux.sv
module cfs_read_mux
    import cfs_pkg::*;
#(
    parameter int NUM_OUT = 16
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_OUT-1:0] enable,
    input  logic [NUM_OUT-1:0] flags,
    input  cfs_berr_t          berr,
    output logic [DATA_W-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            REG_ENABLE: rdata[NUM_OUT-1:0] = enable;
            REG_FLAG: begin
                rdata[NUM_OUT-1:0]  = flags;
                rdata[BERR_LO_POS]  = berr.lo;
                rdata[BERR_HI_POS]  = berr.hi;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/conflict_status_unit.sv
module conflict_status_unit
    import cfs_pkg::*;
#(
    parameter int NUM_OUT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OUT-1:0] conflict_evt,
    input  logic               err_lo_wr,
    input  logic               err_hi_wr,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_req
);

    cfs_wsel_t          wsel;
    logic [NUM_OUT-1:0] enable_q;
    logic [NUM_OUT-1:0] flags;
    logic [NUM_OUT-1:0] flag_clr;
    cfs_berr_t          berr_in;
    cfs_berr_t          berr_clr;
    cfs_berr_t          berr_rec;
    logic               unused_wbits;

    assign wsel         = cfs_decode(reg_wr, reg_addr);
    assign flag_clr     = wsel.fl_we ? reg_wdata[NUM_OUT-1:0] : '0;
    assign berr_in.lo   = err_lo_wr;
    assign berr_in.hi   = err_hi_wr;
    assign berr_clr.lo  = wsel.fl_we & reg_wdata[BERR_LO_POS];
    assign berr_clr.hi  = wsel.fl_we & reg_wdata[BERR_HI_POS];
    assign unused_wbits = ^reg_wdata[BERR_LO_POS-1:NUM_OUT];

    always_ff @(posedge clk) begin
        if (rst)              enable_q <= '0;
        else if (wsel.en_we)  enable_q <= reg_wdata[NUM_OUT-1:0];
    end

    cfs_flag_array #(.NUM_OUT(NUM_OUT)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (conflict_evt),
        .clr_vec (flag_clr),
        .flags   (flags)
    );

    cfs_berr_track u_berr (
        .clk    (clk),
        .rst    (rst),
        .err_in (berr_in),
        .clr_in (berr_clr),
        .rec    (berr_rec)
    );

    cfs_read_mux #(.NUM_OUT(NUM_OUT)) u_rmux (
        .addr   (reg_addr),
        .enable (enable_q),
        .flags  (flags),
        .berr   (berr_rec),
        .rdata  (reg_rdata)
    );

    assign irq_req = |(enable_q & flags);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (enable_q == '0 && flags == '0 && berr_rec == '0 && !irq_req));

    assert_enable_load_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0) |=> (enable_q == $past(reg_wdata[NUM_OUT-1:0])));

    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !irq_req);

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (enable_q == '0) |-> !irq_req);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (err_lo_wr && reg_wr && reg_addr == 2'd1 && reg_wdata[BERR_LO_POS]) |=> berr_rec.lo);

endmodule

// File: tb/conflict_status_unit_test.sv
`timescale 1ns/1ps
module conflict_status_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt = '0;
    logic        elo = 1'b0;
    logic        ehi = 1'b0;
    logic        wr  = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_en = '0;
    logic [15:0] m_fl = '0;
    logic [1:0]  m_be = '0;

    always #2 clk = ~clk;

    conflict_status_unit #(.NUM_OUT(16)) uut (
        .clk          (clk),
        .rst          (rst),
        .conflict_evt (evt),
        .err_lo_wr    (elo),
        .err_hi_wr    (ehi),
        .reg_wr       (wr),
        .reg_addr     (addr),
        .reg_wdata    (wdata),
        .reg_rdata    (rdata),
        .irq_req      (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic cyc(input logic [15:0] e, input logic lo, input logic hi,
                       input logic w, input logic [1:0] a, input logic [31:0] d);
        evt = e; elo = lo; ehi = hi; wr = w; addr = a; wdata = d;
        @(posedge clk);
        if (w && a == 2'd0) m_en = d[15:0];
        if (w && a == 2'd1) begin
            m_fl = m_fl & ~d[15:0];
            if (!(lo || hi)) m_be = m_be & ~d[31:30];
        end
        m_fl = m_fl | e;
        if (lo || hi) m_be = {hi, lo};
        @(negedge clk);
        evt = '0; elo = 1'b0; ehi = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        read_reg(2'd0, v);
        check(req, v, {16'h0, m_en});
        read_reg(2'd1, v);
        check(req, v, {m_be, 14'h0, m_fl});
        check(req, {31'h0, irq}, {31'h0, |(m_en & m_fl)});
    endtask

    initial begin : watchdog
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check_all("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset");

        // R2: enable width, upper bits read zero
        cyc('0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
        read_reg(2'd0, v);
        check("R2 enable readback", v, 32'h0000_FFFF);

        // R3 R4 R5: every output position
        for (int n = 0; n < 16; n++) begin
            cyc(16'(1 << n), 0, 0, 0, 2'd0, '0);
            check_all("R3 set");
            check("R5 irq on", {31'h0, irq}, 32'h1);
            cyc('0, 0, 0, 0, 2'd0, '0);
            check_all("R3 hold");
            cyc('0, 0, 0, 1, 2'd1, ~(32'(1) << n) & 32'h0000_FFFF);
            check_all("R4 other bits cleared, own kept");
            cyc('0, 0, 0, 1, 2'd1, 32'h0);
            check_all("R4 write zero no effect");
            cyc('0, 0, 0, 1, 2'd1, 32'(1) << n);
            check_all("R4 clear");
            check("R5 irq off", {31'h0, irq}, 32'h0);
        end

        // R5: gating by enable
        cyc('0, 0, 0, 1, 2'd0, 32'h0000_00FF);
        cyc(16'hFF00, 0, 0, 0, 2'd0, '0);
        check("R5 masked no irq", {31'h0, irq}, 32'h0);
        check_all("R5 masked");
        cyc('0, 0, 0, 1, 2'd0, 32'h0000_0100);
        check("R5 enable raises irq", {31'h0, irq}, 32'h1);
        cyc('0, 0, 0, 1, 2'd1, 32'h0000_FFFF);
        check_all("R5 cleared");

        // R6 R7 R8: bus-error record
        cyc('0, 1, 0, 0, 2'd0, '0);
        read_reg(2'd1, v);
        check("R6 low error", v, 32'h4000_0000);
        cyc('0, 0, 1, 0, 2'd0, '0);
        read_reg(2'd1, v);
        check("R6 high replaces low", v, 32'h8000_0000);
        cyc('0, 1, 0, 0, 2'd0, '0);
        read_reg(2'd1, v);
        check("R6 low replaces high", v, 32'h4000_0000);
        cyc('0, 1, 1, 0, 2'd0, '0);
        read_reg(2'd1, v);
        check("R7 both halves", v, 32'hC000_0000);
        cyc('0, 0, 0, 1, 2'd1, 32'h0);
        read_reg(2'd1, v);
        check("R8 write zero keeps", v, 32'hC000_0000);
        cyc('0, 0, 0, 1, 2'd1, 32'h4000_0000);
        read_reg(2'd1, v);
        check("R8 clear low", v, 32'h8000_0000);
        cyc('0, 0, 0, 1, 2'd1, 32'h8000_0000);
        read_reg(2'd1, v);
        check("R8 clear high", v, 32'h0);

        // R9: set beats clear
        cyc(16'h0008, 0, 0, 0, 2'd0, '0);
        cyc(16'h0008, 0, 0, 1, 2'd1, 32'h0000_0009);
        check_all("R9 conflict set wins");
        cyc('0, 1, 0, 0, 2'd0, '0);
        cyc('0, 0, 1, 1, 2'd1, 32'hC000_0000);
        read_reg(2'd1, v);
        check("R9 error set wins", v, 32'h8000_0008);
        cyc('0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF);
        check_all("R9 cleanup");

        // R10: reserved bits and unmapped addresses
        cyc(16'h1234, 0, 0, 1, 2'd2, 32'hFFFF_FFFF);
        cyc('0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        check_all("R10 unmapped writes ignored");
        read_reg(2'd2, v);
        check("R10 addr2 reads zero", v, 32'h0);
        read_reg(2'd3, v);
        check("R10 addr3 reads zero", v, 32'h0);
        cyc('0, 0, 0, 1, 2'd1, 32'h3FFF_0000);
        read_reg(2'd1, v);
        check("R10 reserved flag bits", v & 32'h3FFF_0000, 32'h0);

        // random mix: collisions of set and clear across all bits (R9)
        for (int i = 0; i < 400; i++) begin
            logic [15:0] e;
            logic [31:0] d;
            logic lo, hi, w;
            logic [1:0] a;
            e  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            lo = ($urandom % 8) == 0;
            hi = ($urandom % 8) == 0;
            w  = ($urandom % 2) == 0;
            a  = 2'($urandom % 4);
            d  = $urandom;
            cyc(e, lo, hi, w, a, d);
            check_all("R9 random mix");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule